// File: doc/BRIEF.md
# Multi-Tap Ring Delay Buffer

This block keeps one sample memory as a circular store. It has one write pointer and three read taps, and each tap sits a programmable number of samples behind the writer. Each time a sample strobe is accepted, the block stores the incoming 16-bit sample. It then fetches the three delayed samples one after another on the single memory port, presents them together and advances the write pointer by one. The write pointer wraps from the top of the memory back to address zero. A tap's delay is set only by its offset from the write pointer, so a delay change needs no change of sample rate.

After reset the block sweeps the whole memory and writes zero to every word. Until a tap has seen as many samples as its offset, it therefore returns silence rather than stale contents. During the sweep `busy` is high and strobes are dropped. A strobe is also dropped while a previous one is still in progress, so strobes must be spaced at least six clocks apart.

The controller is a five-state machine:

- CLEAR sweeps the memory. It moves to IDLE after the last address has been written.
- IDLE waits. It moves to WRITE on a strobe, capturing the sample and the offsets.
- WRITE stores the sample at the write pointer and moves to READ.
- READ issues one tap read per clock. It moves to FINISH after the last tap.
- FINISH publishes the taps, raises `taps_valid` and advances the pointer, then returns to IDLE.

Reset always forces CLEAR.

Top module: `tap_ring_delay`

## Requirements
- R1: While reset is low, `busy` is 1, `taps_valid` is 0 and `tap_out` is all zeros.
- R2: After reset is released, `busy` stays high for exactly DEPTH clock cycles while zero is written to every word. Samples stored before a reset never reappear after it.
- R3: A `sample_stb` that arrives while `busy` is high is ignored. Nothing is written, the pointer does not move and `taps_valid` is not raised.
- R4: A strobe sampled in IDLE at clock edge P0 makes `taps_valid` high for exactly one cycle, following edge P5. `tap_out` changes only at that edge and holds otherwise.
- R5: Tap k is `tap_out[16k+15:16k]`. It equals the sample accepted `tap_offset[6k+5:6k]` strobes earlier. Offset 0 returns the sample just accepted.
- R6: A tap whose offset exceeds the number of samples accepted since the clear outputs 0.
- R7: The write pointer wraps from DEPTH-1 to 0. Offsets up to DEPTH-1 stay exact across the wrap.
- R8: Offsets and the sample are captured at the accepted strobe. Changing them afterwards does not affect that result, and new offsets take effect on the next strobe.
- R9: A strobe arriving while a previous strobe is still being processed is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | New-sample strobe, one cycle |
| sample_in | input | 16 | Incoming sample |
| tap_offset | input | 18 | Three 6-bit tap offsets in samples; tap k at bits [6k+5:6k] |
| busy | output | 1 | High during the zero sweep |
| taps_valid | output | 1 | One-cycle pulse when all tap outputs are updated |
| tap_out | output | 48 | Three 16-bit delayed samples; tap k at bits [16k+15:16k] |

## Verification
There are two cases where a strobe meets work already in progress. In the first, a strobe lands while the machine is still sweeping the memory or is still fetching taps for the previous sample. The bench provokes this by holding `sample_stb` high across part of the sweep and by pulsing it during a READ cycle of a normal sample. In the second, a tap read in the same sample period falls on the address just written (offset 0), or on an address that has wrapped past zero. Every result is judged against a sample history kept in the bench: a stray accepted strobe would shift every following tap by one sample or insert a foreign value. All offsets from 0 to 63 are swept on each tap over more than three full laps of the memory.

// File: rtl/tap_ring_pkg.sv
package tap_ring_pkg;

    typedef enum logic [2:0] {
        ST_CLEAR,
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_FINISH
    } ring_state_t;

endpackage

// File: rtl/tap_ring_ram.sv
module tap_ring_ram #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    // single port: a write cycle does not update the read register
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end else begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/tap_ring_addr.sv
module tap_ring_addr #(
    parameter int ADDR_W = 6,
    parameter int NTAPS  = 3,
    parameter int IDX_W  = 2
) (
    input  logic [ADDR_W-1:0]       wptr,
    input  logic [NTAPS*ADDR_W-1:0] offsets,
    input  logic [IDX_W-1:0]        sel,
    output logic [ADDR_W-1:0]       rd_addr
);
    logic [ADDR_W-1:0] tap_addr [NTAPS];

    // modulo subtraction: natural wrap of an ADDR_W-bit difference
    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        assign tap_addr[k] = wptr - offsets[k*ADDR_W +: ADDR_W];
    end

    always_comb begin
        rd_addr = '0;
        for (int k = 0; k < NTAPS; k++) begin
            if (sel == IDX_W'(k)) begin
                rd_addr = tap_addr[k];
            end
        end
    end

endmodule

// File: rtl/tap_ring_delay.sv
module tap_ring_delay
    import tap_ring_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int DEPTH_LOG2 = 6,
    parameter int NTAPS      = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sample_stb,
    input  logic [DATA_W-1:0]         sample_in,
    input  logic [NTAPS*DEPTH_LOG2-1:0] tap_offset,
    output logic                      busy,
    output logic                      taps_valid,
    output logic [NTAPS*DATA_W-1:0]   tap_out
);
    localparam int AW       = DEPTH_LOG2;
    localparam int DEPTH    = 1 << AW;
    localparam int IW       = (NTAPS > 1) ? $clog2(NTAPS) : 1;
    localparam int LAST_TAP = NTAPS - 1;
    localparam int STAGE_W  = (NTAPS - 1) * DATA_W;

    ring_state_t state_q, state_d;

    logic [AW-1:0]           clr_cnt_q;
    logic [AW-1:0]           wptr_q;
    logic [IW-1:0]           idx_q;
    logic [DATA_W-1:0]       smp_q;
    logic [NTAPS*AW-1:0]     off_q;
    logic [STAGE_W-1:0]      stage_q;
    logic [NTAPS*DATA_W-1:0] tap_q;
    logic                    valid_q;

    logic              ram_we;
    logic [AW-1:0]     ram_addr;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] ram_rdata;
    logic [AW-1:0]     rd_addr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR:  if (clr_cnt_q == AW'(DEPTH - 1)) state_d = ST_IDLE;
            ST_IDLE:   if (sample_stb) state_d = ST_WRITE;
            ST_WRITE:  state_d = ST_READ;
            ST_READ:   if (idx_q == IW'(LAST_TAP)) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_CLEAR;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_cnt_q <= '0;
            wptr_q    <= '0;
            idx_q     <= '0;
            smp_q     <= '0;
            off_q     <= '0;
            stage_q   <= '0;
            tap_q     <= '0;
            valid_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            case (state_q)
                ST_CLEAR: clr_cnt_q <= clr_cnt_q + 1'b1;
                ST_IDLE: begin
                    if (sample_stb) begin
                        smp_q <= sample_in;
                        off_q <= tap_offset;
                    end
                end
                ST_WRITE: idx_q <= '0;
                ST_READ: begin
                    idx_q <= idx_q + 1'b1;
                    // data of read k arrives while read k+1 is issued
                    for (int k = 0; k < LAST_TAP; k++) begin
                        if (idx_q == IW'(k + 1)) begin
                            stage_q[k*DATA_W +: DATA_W] <= ram_rdata;
                        end
                    end
                end
                ST_FINISH: begin
                    for (int k = 0; k < LAST_TAP; k++) begin
                        tap_q[k*DATA_W +: DATA_W] <= stage_q[k*DATA_W +: DATA_W];
                    end
                    tap_q[LAST_TAP*DATA_W +: DATA_W] <= ram_rdata;
                    wptr_q  <= wptr_q + 1'b1;
                    valid_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    tap_ring_addr #(
        .ADDR_W (AW),
        .NTAPS  (NTAPS),
        .IDX_W  (IW)
    ) u_addr (
        .wptr    (wptr_q),
        .offsets (off_q),
        .sel     (idx_q),
        .rd_addr (rd_addr)
    );

    always_comb begin
        ram_we    = 1'b0;
        ram_addr  = rd_addr;
        ram_wdata = smp_q;
        if (state_q == ST_CLEAR) begin
            ram_we    = 1'b1;
            ram_addr  = clr_cnt_q;
            ram_wdata = '0;
        end else if (state_q == ST_WRITE) begin
            ram_we    = 1'b1;
            ram_addr  = wptr_q;
        end
    end

    tap_ring_ram #(
        .DATA_W (DATA_W),
        .ADDR_W (AW)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    assign busy       = (state_q == ST_CLEAR);
    assign taps_valid = valid_q;
    assign tap_out    = tap_q;

    // sweep ends only after the last address
    assert_sweep_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(clr_cnt_q) == AW'(DEPTH - 1)));

    assert_busy_no_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !taps_valid);

    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        taps_valid |=> !taps_valid);

    assert_taps_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !taps_valid |-> $stable(tap_out));

    assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr_q != $past(wptr_q)) |-> (taps_valid && (wptr_q == $past(wptr_q) + 1'b1)));

endmodule

// File: tb/tap_ring_delay_bench.sv
module tap_ring_delay_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW    = 16;
    localparam int AW    = 6;
    localparam int NT    = 3;
    localparam int DEPTH = 1 << AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_stb = 1'b0;
    logic [DW-1:0]     sample_in = '0;
    logic [NT*AW-1:0]  tap_offset = '0;
    logic              busy;
    logic              taps_valid;
    logic [NT*DW-1:0]  tap_out;

    int n_cmp = 0;
    int n_bad = 0;
    int hist [0:511];
    int nsmp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tap_ring_delay #(
        .DATA_W     (DW),
        .DEPTH_LOG2 (AW),
        .NTAPS      (NT)
    ) u_tap_ring_delay (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .sample_in  (sample_in),
        .tap_offset (tap_offset),
        .busy       (busy),
        .taps_valid (taps_valid),
        .tap_out    (tap_out)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic do_reset();
        int busy_cycles = 0;
        int valid_seen  = 0;
        @(negedge clk);
        rst_n      = 1'b0;
        sample_stb = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", int'(busy), 1);
        check("R1", "valid in reset", int'(taps_valid), 0);
        check("R1", "taps zero in reset", int'(tap_out == '0), 1);
        rst_n = 1'b1;
        for (int c = 0; c < DEPTH + 4; c++) begin
            if (busy) busy_cycles++;
            if (taps_valid) valid_seen++;
            // R3: strobes offered during the sweep
            sample_stb = (c >= 2 && c < 12);
            sample_in  = 16'hBEEF;
            @(negedge clk);
        end
        sample_stb = 1'b0;
        check("R2", "busy length", busy_cycles, DEPTH);
        check("R3", "valid during sweep", valid_seen, 0);
        check("R2", "busy low after sweep", int'(busy), 0);
        nsmp = 0;
    endtask

    task automatic send(input logic [DW-1:0] s, input int o0, input int o1, input int o2,
                        input bit glitch, input string tag_ovr);
        int    off [NT];
        int    expv [NT];
        string tg;
        off[0] = o0; off[1] = o1; off[2] = o2;
        sample_stb = 1'b1;
        sample_in  = s;
        tap_offset = {AW'(o2), AW'(o1), AW'(o0)};
        @(negedge clk);
        // R8: inputs scrambled after the accepted strobe
        sample_stb = 1'b0;
        sample_in  = 16'h0F0F;
        tap_offset = '1;
        hist[nsmp] = int'(s);
        @(negedge clk);
        @(negedge clk);
        if (glitch) begin
            sample_stb = 1'b1;
            sample_in  = 16'hDEAD;
        end
        @(negedge clk);
        sample_stb = 1'b0;
        @(negedge clk);
        check("R4", "valid before latency", int'(taps_valid), 0);
        @(negedge clk);
        check("R4", "valid at latency", int'(taps_valid), 1);
        for (int k = 0; k < NT; k++) begin
            expv[k] = (off[k] > nsmp) ? 0 : hist[nsmp - off[k]];
            if (tag_ovr != "")          tg = tag_ovr;
            else if (off[k] > nsmp)     tg = "R6";
            else if (nsmp >= DEPTH)     tg = "R7";
            else                        tg = "R5";
            check(tg, $sformatf("tap%0d n=%0d off=%0d", k, nsmp, off[k]),
                  int'(tap_out[k*DW +: DW]), expv[k]);
        end
        @(negedge clk);
        check("R4", "valid single cycle", int'(taps_valid), 0);
        check("R4", "tap0 held", int'(tap_out[0 +: DW]), expv[0]);
        nsmp++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R4 watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        do_reset();
        // R3: stray strobes during sweep must not have written or advanced
        send(16'h1111, 0, 1, 63, 1'b0, "R3");
        for (int n = 1; n < 200; n++) begin
            send(16'(n * 40503 + 4660), n % DEPTH, (DEPTH - 1) - (n % DEPTH),
                 (n * 7 + 3) % DEPTH, (n % 5) == 0, "");
        end
        send(16'h2222, 1, 2, 3, 1'b0, "R8");
        send(16'h3333, 0, 5, 1, 1'b0, "R8");
        // R9: strobe inside processing ignored
        send(16'hAAAA, 0, 0, 0, 1'b1, "R9");
        send(16'h5555, 1, 0, 2, 1'b0, "R9");
        // R2: second reset wipes earlier contents
        do_reset();
        send(16'h7777, 5, 10, 63, 1'b0, "R2");
        send(16'h6666, 1, 2, 0, 1'b0, "R2");
        finish_run();
    end

endmodule